// File: doc/BRIEF.md
# Packed Colour Palette RAM

This block holds a 256-colour lookup table for a display pipeline. Software reaches it through a word-wide register port: every 32-bit word carries two 16-bit colour entries, so 128 words cover the whole table. Each entry packs three 5-bit channels plus an intensity flag in its top bit. Words are read back exactly as they were written.

A separate pixel-side port takes an 8-bit colour index and returns a 24-bit colour one clock later. The entry is widened to 8 bits per channel by appending three zero bits, and the intensity flag plays no part in it. A swap control exchanges the first and third channels, so the same table can drive panels wired in either channel order. Address decoding of the register space and unpacking of pixel data from memory are handled by neighbouring blocks.

Top module: `clut_store`

## Requirements
- R1: While reset is asserted, and after it until the first access, `bus_rdata` and `pix_rgb` are zero.
- R2: A bus write (`bus_sel`=1, `bus_we`=1) stores `bus_wdata` at word `bus_addr`. A bus read (`bus_sel`=1, `bus_we`=0) presents that word on `bus_rdata` in the cycle after the read, with all 32 bits unchanged, including bits 15 and 31.
- R3: `bus_rdata` keeps its value in every cycle that carries no bus read, including cycles with a bus write.
- R4: `pix_idx[0]` selects the entry within word `pix_idx[7:1]`: 0 selects bits 15:0 and 1 selects bits 31:16.
- R5: Within an entry, channel bits 4:0 become `pix_rgb[7:0]`, bits 9:5 become `pix_rgb[15:8]` and bits 14:10 become `pix_rgb[23:16]`. Each channel is widened as {channel, 3'b000}.
- R6: Entry bit 15 (word bits 15 and 31) has no effect on `pix_rgb`.
- R7: `swap_rb` is sampled together with `pix_idx`. When it is 1, the contents of `pix_rgb[7:0]` and `pix_rgb[23:16]` are exchanged. `pix_rgb[15:8]` is the same for both values of `swap_rb`.
- R8: `pix_rgb` shows the colour for the `pix_idx` and `swap_rb` sampled at the previous clock edge, and holds it until the next edge.
- R9: A pixel lookup in the same cycle as a bus write to the same word returns the old content. A lookup in the following cycle returns the new content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read (when `bus_sel` is 1) |
| bus_addr | input | 7 | Word index (IDX_W-1 bits) |
| bus_wdata | input | 32 | Word to store (two packed entries) |
| bus_rdata | output | 32 | Word returned by the last read |
| pix_idx | input | 8 | Colour index (IDX_W bits) |
| swap_rb | input | 1 | Exchange first and third channels |
| pix_rgb | output | 24 | Widened colour, third channel in the top byte |

## Verification
The bench builds the block with its default parameters: 8-bit indices, 5-bit channels and 8-bit outputs. At that size every one of the 128 words can be written and read back, and every one of the 256 indices can be looked up with the swap control both off and on. The sweeps use a pattern that sets the intensity bits in some words and clears them in others. They are followed by directed checks of the output timing, of bus-read holding and of a lookup that collides with a write to the same word.

// File: rtl/pal_pkg.sv
package pal_pkg;

  // Which 16-bit half of a packed word an index points at.
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  localparam int CHANNELS = 3;
  localparam int ENTRIES_PER_WORD = 2;

endpackage

// File: rtl/pal_word_ram.sv
// Word store split into a channel array (both ports) and a flag array
// (bus port only), so the pixel port reads only the bits it needs.
module pal_word_ram
  import pal_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int CH_W   = 5,
  localparam int PAY_W   = CHANNELS * CH_W,
  localparam int ENTRY_W = PAY_W + 1,
  localparam int WORD_W  = ENTRIES_PER_WORD * ENTRY_W,
  localparam int CHAN_W  = ENTRIES_PER_WORD * PAY_W,
  localparam int DEPTH   = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_sel,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [CHAN_W-1:0] b_chan
);

  logic [CHAN_W-1:0]           chan_mem [DEPTH];
  logic [ENTRIES_PER_WORD-1:0] flag_mem [DEPTH];

  logic [CHAN_W-1:0]           chan_in;
  logic [ENTRIES_PER_WORD-1:0] flag_in;
  logic [CHAN_W-1:0]           a_chan_q;
  logic [ENTRIES_PER_WORD-1:0] a_flag_q;
  logic [CHAN_W-1:0]           b_chan_q;

  // Split each incoming word into channel bits and per-entry flags,
  // and rebuild the raw word from the two read registers.
  for (genvar h = 0; h < ENTRIES_PER_WORD; h++) begin : g_half
    assign chan_in[h*PAY_W +: PAY_W]       = a_wdata[h*ENTRY_W +: PAY_W];
    assign flag_in[h]                      = a_wdata[h*ENTRY_W + PAY_W];
    assign a_rdata[h*ENTRY_W +: PAY_W]     = a_chan_q[h*PAY_W +: PAY_W];
    assign a_rdata[h*ENTRY_W + PAY_W]      = a_flag_q[h];
  end

  // Write port
  always_ff @(posedge clk) begin
    if (a_sel && a_we) begin
      chan_mem[a_addr] <= chan_in;
      flag_mem[a_addr] <= flag_in;
    end
  end

  // Bus read port: updates only on a read, otherwise holds
  always_ff @(posedge clk) begin
    if (rst) begin
      a_chan_q <= '0;
      a_flag_q <= '0;
    end else if (a_sel && !a_we) begin
      a_chan_q <= chan_mem[a_addr];
      a_flag_q <= flag_mem[a_addr];
    end
  end

  // Pixel read port: read-before-write against the bus port
  always_ff @(posedge clk) begin
    if (rst) begin
      b_chan_q <= '0;
    end else begin
      b_chan_q <= chan_mem[b_addr];
    end
  end

  assign b_chan = b_chan_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(a_sel && !a_we) |=> $stable(a_rdata)); // R3

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
    (a_sel && a_we) ##1 (a_sel && !a_we && a_addr == $past(a_addr))
    |=> a_rdata == $past(a_wdata, 2)); // R2

endmodule

// File: rtl/pal_entry_expand.sv
// Picks one entry out of a channel word, widens each channel and
// optionally exchanges the outer channels.
module pal_entry_expand
  import pal_pkg::*;
#(
  parameter int CH_W  = 5,
  parameter int OUT_W = 8,
  localparam int PAY_W  = CHANNELS * CH_W,
  localparam int CHAN_W = ENTRIES_PER_WORD * PAY_W,
  localparam int SHIFT  = OUT_W - CH_W
) (
  input  logic [CHAN_W-1:0]         chan,
  input  half_e                     half,
  input  logic                      swap,
  output logic [CHANNELS*OUT_W-1:0] rgb
);

  logic [OUT_W-1:0] wide [CHANNELS];

  for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
    logic [CH_W-1:0] raw;
    assign raw     = (half == HALF_HI) ? chan[PAY_W + i*CH_W +: CH_W]
                                       : chan[i*CH_W +: CH_W];
    assign wide[i] = OUT_W'(raw) << SHIFT;
  end

  for (genvar i = 0; i < CHANNELS; i++) begin : g_out
    assign rgb[i*OUT_W +: OUT_W] = swap ? wide[CHANNELS-1-i] : wide[i];
  end

endmodule

// File: rtl/clut_store.sv
module clut_store
  import pal_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CH_W  = 5,
  parameter int OUT_W = 8,
  localparam int ADDR_W  = IDX_W - 1,
  localparam int PAY_W   = CHANNELS * CH_W,
  localparam int ENTRY_W = PAY_W + 1,
  localparam int WORD_W  = ENTRIES_PER_WORD * ENTRY_W,
  localparam int CHAN_W  = ENTRIES_PER_WORD * PAY_W,
  localparam int RGB_W   = CHANNELS * OUT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [IDX_W-1:0]  pix_idx,
  input  logic              swap_rb,
  output logic [RGB_W-1:0]  pix_rgb
);

  logic [CHAN_W-1:0] chan_word;
  half_e             half_q;
  logic              swap_q;
  logic              live_q;

  pal_word_ram #(
    .ADDR_W (ADDR_W),
    .CH_W   (CH_W)
  ) u_ram (
    .clk     (clk),
    .rst     (rst),
    .a_sel   (bus_sel),
    .a_we    (bus_we),
    .a_addr  (bus_addr),
    .a_wdata (bus_wdata),
    .a_rdata (bus_rdata),
    .b_addr  (pix_idx[IDX_W-1:1]),
    .b_chan  (chan_word)
  );

  // Half select and swap travel alongside the RAM read register
  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= HALF_LO;
      swap_q <= 1'b0;
      live_q <= 1'b0;
    end else begin
      half_q <= half_e'(pix_idx[0]);
      swap_q <= swap_rb;
      live_q <= 1'b1;
    end
  end

  pal_entry_expand #(
    .CH_W  (CH_W),
    .OUT_W (OUT_W)
  ) u_expand (
    .chan (chan_word),
    .half (half_q),
    .swap (swap_q),
    .rgb  (pix_rgb)
  );

  AST_SWAP_MIRROR: assert property (@(posedge clk) disable iff (rst)
    (live_q && pix_idx == $past(pix_idx) && !$past(bus_sel && bus_we)
      && swap_rb != $past(swap_rb))
    |=> pix_rgb[OUT_W-1:0] == $past(pix_rgb[RGB_W-1:RGB_W-OUT_W])); // R7

  AST_MID_KEEP: assert property (@(posedge clk) disable iff (rst)
    (live_q && pix_idx == $past(pix_idx) && !$past(bus_sel && bus_we))
    |=> pix_rgb[2*OUT_W-1:OUT_W] == $past(pix_rgb[2*OUT_W-1:OUT_W])); // R7

endmodule

// File: tb/sim_clut_store.sv
module sim_clut_store;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx = '0;
  logic        swap_rb = 1'b0;
  logic [23:0] pix_rgb;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  clut_store u0 (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pix_idx   (pix_idx),
    .swap_rb   (swap_rb),
    .pix_rgb   (pix_rgb)
  );

  function automatic logic [31:0] pat(int a);
    return (32'(a) * 32'h0107_0B2D) ^ 32'h9A5C_C3A5;
  endfunction

  function automatic logic [23:0] exp_rgb(logic [31:0] w, logic hi, logic sw);
    logic [15:0] e;
    logic [7:0]  c0, c1, c2;
    e  = hi ? w[31:16] : w[15:0];
    c0 = {e[4:0], 3'b000};
    c1 = {e[9:5], 3'b000};
    c2 = {e[14:10], 3'b000};
    return sw ? {c0, c1, c2} : {c2, c1, c0};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_write(int a, logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 7'(a); bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(int a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 7'(a);
    tick();
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic look(int idx, logic sw, output logic [23:0] c);
    pix_idx = 8'(idx); swap_rb = sw;
    tick();
    c = pix_rgb;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] w, held;
    logic [23:0] c, c_a, c_b;

    // R1: reset values
    repeat (3) tick();
    chk("R1 rdata in reset", bus_rdata, 32'h0);
    chk("R1 rgb in reset", {8'h0, pix_rgb}, 32'h0);
    rst = 1'b0;
    #1;
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    chk("R1 rgb after reset", {8'h0, pix_rgb}, 32'h0);

    // R2: fill every word, read every word back raw
    for (int a = 0; a < 128; a++) bus_write(a, pat(a));
    for (int a = 0; a < 128; a++) begin
      bus_read(a, w);
      chk("R2 raw readback", w, pat(a));
    end

    // R4 R5 R7: every index, both swap settings
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 256; i++) begin
        look(i, s[0], c);
        chk(s == 0 ? "R4 R5 lookup" : "R7 swapped lookup",
            {8'h0, c}, {8'h0, exp_rgb(pat(i >> 1), i[0], s[0])});
      end
    end

    // R6: intensity bits do not change the colour
    bus_write(5, 32'h1357_2468 & 32'h7FFF_7FFF);
    look(10, 1'b0, c_a);
    look(11, 1'b0, c_b);
    bus_write(5, 32'h1357_2468 | 32'h8000_8000);
    look(10, 1'b0, c);
    chk("R6 low entry flag", {8'h0, c}, {8'h0, c_a});
    look(11, 1'b0, c);
    chk("R6 high entry flag", {8'h0, c}, {8'h0, c_b});
    chk("R6 expected colour", {8'h0, c}, {8'h0, exp_rgb(32'h1357_2468, 1'b1, 1'b0)});
    bus_read(5, w);
    chk("R2 flag bits kept", w, 32'h1357_2468 | 32'h8000_8000);

    // R8: one-cycle latency, holds between edges
    look(40, 1'b0, c);
    chk("R8 first lookup", {8'h0, c}, {8'h0, exp_rgb(pat(20), 1'b0, 1'b0)});
    pix_idx = 8'd201; swap_rb = 1'b1;
    #3;
    chk("R8 held before edge", {8'h0, pix_rgb}, {8'h0, exp_rgb(pat(20), 1'b0, 1'b0)});
    tick();
    chk("R8 after edge", {8'h0, pix_rgb}, {8'h0, exp_rgb(pat(100), 1'b1, 1'b1)});

    // R3: rdata holds through writes and idle cycles
    bus_read(3, held);
    bus_write(9, 32'hDEAD_BEEF);
    tick();
    tick();
    chk("R3 rdata held", bus_rdata, held);
    chk("R3 rdata value", held, pat(3));

    // R9: lookup colliding with a write sees old data, then new data
    pix_idx = 8'd60; swap_rb = 1'b0;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 7'd30; bus_wdata = 32'h0421_7C1F;
    tick();
    bus_sel = 1'b0; bus_we = 1'b0;
    chk("R9 old content", {8'h0, pix_rgb}, {8'h0, exp_rgb(pat(30), 1'b0, 1'b0)});
    tick();
    chk("R9 new content", {8'h0, pix_rgb}, {8'h0, exp_rgb(32'h0421_7C1F, 1'b0, 1'b0)});
    chk("R5 channel placement", {8'h0, pix_rgb}, 32'h00F8_00F8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule